// File: doc/BRIEF.md
# Equalized Carrier Output Multiplexer with Block and Frame Markers

This block sits after the channel equalizer of a multicarrier terrestrial broadcast receiver. For each carrier it takes the corrected I and Q values, a 4-bit confidence factor, an 8-bit squared channel magnitude, the carrier's kind and a flag for the first non-zero carrier of the symbol. It then sends them out over two clock cycles on an 8-bit data bus and two 4-bit side buses. A phase-enable output tells a downstream consumer which half of the carrier is on the pins. Carriers leave in the order in which they are offered, so natural carrier order at the input gives natural order at the output.

Alongside the data the block drives marker strobes. These are a block-start strobe on the first non-zero carrier, data-valid and TPS-valid qualifiers, and a frame strobe and a superframe strobe. The markers come from the symbol index within the frame, the frame index within the superframe (four frames of 68 symbols) and the FFT size. The first non-zero carrier is always a continual pilot, so the block keeps both qualifiers low on it.

A three-state machine drives the sequence. ST_IDLE holds the outputs at zero. ST_IPH presents the I half and ST_QPH presents the Q half. The transitions are:
- T_START: ST_IDLE to ST_IPH, when a carrier is offered.
- T_WAIT: ST_IDLE stays in ST_IDLE, when no carrier is offered.
- T_SWAP: ST_IPH to ST_QPH, which always happens.
- T_NEXT: ST_QPH to ST_IPH, when another carrier is offered.
- T_END: ST_QPH to ST_IDLE, when no carrier is offered.

Top module: `eqmux_top`

## Requirements
- R1: When `car_vld` is high on a clock edge where `out_iphase` is low, the carrier is accepted. In the next cycle `out_data` equals `car_i` and `out_iphase` is 1. In the cycle after that, `out_data` equals `car_q` and `out_iphase` is 0.
- R2: When `car_vld` is high on an edge where `out_iphase` is 1, the offered carrier is ignored. The Q cycle still shows the previous carrier's Q, and if no further offer comes the outputs then return to idle.
- R3: `out_side_a` carries the confidence factor during the I cycle and bits 7:4 of the squared magnitude during the Q cycle.
- R4: `out_side_b` carries bits 3:0 of the squared magnitude in both cycles of a carrier.
- R5: `out_bstart` is 1 in both cycles of a carrier offered with `car_first` set to 1.
- R6: On a carrier with `car_first` set to 1, `out_dvalid` and `out_tvalid` are 0 whatever the value of `car_kind`.
- R7: `car_kind` is encoded as 0 for pilot, 1 for data, 2 for TPS and 3 for other. `out_dvalid` is 1 in both cycles for kind 1 and `out_tvalid` is 1 in both cycles for kind 2. Kinds 0 and 3 raise neither.
- R8: `out_frame` is 1 exactly when `out_dvalid` is 1 and the carrier's `sym_idx` is 0.
- R9: With `mode_8k` set to 1, `out_sframe` equals `out_frame`. With `mode_8k` set to 0, `out_sframe` is `out_frame` gated by `frm_idx` being 0.
- R10: After reset, and whenever no carrier is in progress, all outputs are 0. An asynchronous reset in mid-carrier clears them at once.
- R11: An offer made during the Q cycle is accepted with no gap. The next cycle is the I cycle of the new carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock, twice the carrier rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_vld | input | 1 | Carrier offered this cycle |
| car_i | input | 8 | Equalized in-phase value |
| car_q | input | 8 | Equalized quadrature value |
| car_conf | input | 4 | Confidence factor |
| car_h2 | input | 8 | Squared channel magnitude |
| car_kind | input | 2 | 0 pilot, 1 data, 2 TPS, 3 other |
| car_first | input | 1 | First non-zero carrier of the symbol |
| sym_idx | input | 7 | Symbol index within the frame |
| frm_idx | input | 2 | Frame index within the superframe |
| mode_8k | input | 1 | 1 for the large FFT size, 0 for the small one |
| out_data | output | 8 | I in the first cycle, Q in the second |
| out_side_a | output | 4 | Confidence during I, magnitude high nibble during Q |
| out_side_b | output | 4 | Magnitude low nibble |
| out_iphase | output | 1 | 1 during the I cycle |
| out_bstart | output | 1 | Block-start strobe |
| out_dvalid | output | 1 | Regular data carrier |
| out_tvalid | output | 1 | TPS carrier |
| out_frame | output | 1 | Data of the first symbol of a frame |
| out_sframe | output | 1 | Data of the first symbol of a superframe |

## Verification
The block-start strobe and the frame markers can fall in the same cycle. This happens when the first non-zero carrier of symbol 0 of frame 0 comes tagged as a data carrier. A table row provokes exactly that case, and the expected result is block-start high with data-valid, frame and superframe all low. Nearby rows use symbol 0 data carriers with no first flag, so each marker is seen to rise on its own. Carrier acceptance can also coincide with the Q half of the previous carrier. The table is walked back to back, so every row after the first is offered during the previous row's Q cycle, and each I and Q value is compared with its own row.

// File: rtl/eqmux_pkg.sv
package eqmux_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IPH  = 2'd1,
        ST_QPH  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        KIND_PILOT = 2'd0,
        KIND_DATA  = 2'd1,
        KIND_TPS   = 2'd2,
        KIND_OTHER = 2'd3
    } kind_e;

endpackage

// File: rtl/eqmux_fsm.sv
module eqmux_fsm
    import eqmux_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   car_vld,
    output phase_e state,
    output logic   load,
    output logic   in_i,
    output logic   in_q
);

    phase_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = car_vld ? ST_IPH : ST_IDLE;   // T_START / T_WAIT
            ST_IPH:  state_nxt = ST_QPH;                       // T_SWAP
            ST_QPH:  state_nxt = car_vld ? ST_IPH : ST_IDLE;   // T_NEXT / T_END
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        in_i = 1'b0;
        in_q = 1'b0;
        load = 1'b0;
        unique case (state)
            ST_IDLE: load = car_vld;
            ST_IPH:  in_i = 1'b1;
            ST_QPH:  begin
                in_q = 1'b1;
                load = car_vld;
            end
            default: load = 1'b0;
        endcase
    end

endmodule

// File: rtl/eqmux_capture.sv
module eqmux_capture #(
    parameter int DW    = 8,
    parameter int SW    = 4,
    parameter int SYM_W = 7,
    parameter int FRM_W = 2,
    localparam int HW   = 2 * SW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DW-1:0]    car_i,
    input  logic [DW-1:0]    car_q,
    input  logic [SW-1:0]    car_conf,
    input  logic [HW-1:0]    car_h2,
    input  logic [1:0]       car_kind,
    input  logic             car_first,
    input  logic [SYM_W-1:0] sym_idx,
    input  logic [FRM_W-1:0] frm_idx,
    input  logic             mode_8k,
    output logic [DW-1:0]    c_i,
    output logic [DW-1:0]    c_q,
    output logic [SW-1:0]    c_conf,
    output logic [HW-1:0]    c_h2,
    output logic [1:0]       c_kind,
    output logic             c_first,
    output logic [SYM_W-1:0] c_sym,
    output logic [FRM_W-1:0] c_frm,
    output logic             c_8k
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_i     <= '0;
            c_q     <= '0;
            c_conf  <= '0;
            c_h2    <= '0;
            c_kind  <= '0;
            c_first <= 1'b0;
            c_sym   <= '0;
            c_frm   <= '0;
            c_8k    <= 1'b0;
        end else if (load) begin
            c_i     <= car_i;
            c_q     <= car_q;
            c_conf  <= car_conf;
            c_h2    <= car_h2;
            c_kind  <= car_kind;
            c_first <= car_first;
            c_sym   <= sym_idx;
            c_frm   <= frm_idx;
            c_8k    <= mode_8k;
        end
    end

endmodule

// File: rtl/eqmux_marker.sv
module eqmux_marker
    import eqmux_pkg::*;
#(
    parameter int SYM_W = 7,
    parameter int FRM_W = 2
) (
    input  logic             active,
    input  logic [1:0]       c_kind,
    input  logic             c_first,
    input  logic [SYM_W-1:0] c_sym,
    input  logic [FRM_W-1:0] c_frm,
    input  logic             c_8k,
    output logic             m_bstart,
    output logic             m_dvalid,
    output logic             m_tvalid,
    output logic             m_frame,
    output logic             m_sframe
);

    logic is_data, is_tps, first_sym, first_frm;

    always_comb begin
        is_data = 1'b0;
        is_tps  = 1'b0;
        unique case (kind_e'(c_kind))
            KIND_DATA:  is_data = 1'b1;
            KIND_TPS:   is_tps  = 1'b1;
            KIND_PILOT: is_data = 1'b0;
            KIND_OTHER: is_tps  = 1'b0;
            default:    is_data = 1'b0;
        endcase
    end

    assign first_sym = (c_sym == '0);
    assign first_frm = (c_frm == '0);

    always_comb begin
        m_bstart = active && c_first;
        m_dvalid = active && !c_first && is_data;
        m_tvalid = active && !c_first && is_tps;
        m_frame  = m_dvalid && first_sym;
        m_sframe = m_frame && (c_8k || first_frm);
    end

endmodule

// File: rtl/eqmux_top.sv
module eqmux_top
    import eqmux_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SW          = 4,
    parameter int SYMS_PER_FR = 68,
    parameter int FRS_PER_SF  = 4,
    localparam int HW         = 2 * SW,
    localparam int SYM_W      = $clog2(SYMS_PER_FR),
    localparam int FRM_W      = $clog2(FRS_PER_SF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             car_vld,
    input  logic [DW-1:0]    car_i,
    input  logic [DW-1:0]    car_q,
    input  logic [SW-1:0]    car_conf,
    input  logic [HW-1:0]    car_h2,
    input  logic [1:0]       car_kind,
    input  logic             car_first,
    input  logic [SYM_W-1:0] sym_idx,
    input  logic [FRM_W-1:0] frm_idx,
    input  logic             mode_8k,
    output logic [DW-1:0]    out_data,
    output logic [SW-1:0]    out_side_a,
    output logic [SW-1:0]    out_side_b,
    output logic             out_iphase,
    output logic             out_bstart,
    output logic             out_dvalid,
    output logic             out_tvalid,
    output logic             out_frame,
    output logic             out_sframe
);

    phase_e             state;
    logic               load, in_i, in_q;
    logic [DW-1:0]      c_i, c_q;
    logic [SW-1:0]      c_conf;
    logic [HW-1:0]      c_h2;
    logic [1:0]         c_kind;
    logic               c_first, c_8k;
    logic [SYM_W-1:0]   c_sym;
    logic [FRM_W-1:0]   c_frm;

    eqmux_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .car_vld (car_vld),
        .state   (state),
        .load    (load),
        .in_i    (in_i),
        .in_q    (in_q)
    );

    eqmux_capture #(
        .DW (DW), .SW (SW), .SYM_W (SYM_W), .FRM_W (FRM_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .car_i     (car_i),
        .car_q     (car_q),
        .car_conf  (car_conf),
        .car_h2    (car_h2),
        .car_kind  (car_kind),
        .car_first (car_first),
        .sym_idx   (sym_idx),
        .frm_idx   (frm_idx),
        .mode_8k   (mode_8k),
        .c_i       (c_i),
        .c_q       (c_q),
        .c_conf    (c_conf),
        .c_h2      (c_h2),
        .c_kind    (c_kind),
        .c_first   (c_first),
        .c_sym     (c_sym),
        .c_frm     (c_frm),
        .c_8k      (c_8k)
    );

    eqmux_marker #(
        .SYM_W (SYM_W), .FRM_W (FRM_W)
    ) u_mark (
        .active   (in_i || in_q),
        .c_kind   (c_kind),
        .c_first  (c_first),
        .c_sym    (c_sym),
        .c_frm    (c_frm),
        .c_8k     (c_8k),
        .m_bstart (out_bstart),
        .m_dvalid (out_dvalid),
        .m_tvalid (out_tvalid),
        .m_frame  (out_frame),
        .m_sframe (out_sframe)
    );

    always_comb begin
        out_data   = '0;
        out_side_a = '0;
        out_side_b = '0;
        out_iphase = 1'b0;
        unique case (state)
            ST_IDLE: out_iphase = 1'b0;
            ST_IPH: begin
                out_data   = c_i;
                out_side_a = c_conf;
                out_side_b = c_h2[SW-1:0];
                out_iphase = 1'b1;
            end
            ST_QPH: begin
                out_data   = c_q;
                out_side_a = c_h2[HW-1:SW];
                out_side_b = c_h2[SW-1:0];
            end
            default: out_iphase = 1'b0;
        endcase
    end

endmodule

// File: rtl/eqmux_chk.sv
module eqmux_chk #(
    parameter int DW = 8,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          car_vld,
    input logic [DW-1:0] car_i,
    input logic [SW-1:0] car_conf,
    input logic [DW-1:0] out_data,
    input logic [SW-1:0] out_side_a,
    input logic [SW-1:0] out_side_b,
    input logic          out_iphase,
    input logic          out_bstart,
    input logic          out_dvalid,
    input logic          out_tvalid,
    input logic          out_frame,
    input logic          out_sframe
);

    AST_ACCEPT_I: assert property (@(posedge clk) disable iff (!rst_n)
        car_vld && !out_iphase |=> out_iphase && out_data == $past(car_i)); // R1

    AST_CONF_ON_I: assert property (@(posedge clk) disable iff (!rst_n)
        car_vld && !out_iphase |=> out_side_a == $past(car_conf)); // R3

    AST_I_THEN_Q: assert property (@(posedge clk) disable iff (!rst_n)
        out_iphase |=> !out_iphase); // R1

    AST_IGNORE_IN_I: assert property (@(posedge clk) disable iff (!rst_n)
        out_iphase && car_vld |=> !out_iphase && $stable(out_side_b)); // R2

    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_iphase |=> $stable(out_side_b)); // R4

    AST_KMIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_bstart |-> !out_dvalid && !out_tvalid); // R6

    AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_dvalid && out_tvalid)); // R7

    AST_FRAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame |-> out_dvalid); // R8

    AST_SF_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        out_sframe |-> out_frame); // R9

    AST_BSTART_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        out_iphase && out_bstart |=> out_bstart); // R5

endmodule

bind eqmux_top eqmux_chk #(.DW (DW), .SW (SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .car_vld    (car_vld),
    .car_i      (car_i),
    .car_conf   (car_conf),
    .out_data   (out_data),
    .out_side_a (out_side_a),
    .out_side_b (out_side_b),
    .out_iphase (out_iphase),
    .out_bstart (out_bstart),
    .out_dvalid (out_dvalid),
    .out_tvalid (out_tvalid),
    .out_frame  (out_frame),
    .out_sframe (out_sframe)
);

// File: tb/tb_eqmux_top.sv
`timescale 1ns/100ps
module tb_eqmux_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car_vld = 1'b0;
    logic [7:0] car_i = '0, car_q = '0, car_h2 = '0;
    logic [3:0] car_conf = '0;
    logic [1:0] car_kind = '0;
    logic       car_first = 1'b0;
    logic [6:0] sym_idx = '0;
    logic [1:0] frm_idx = '0;
    logic       mode_8k = 1'b0;
    logic [7:0] out_data;
    logic [3:0] out_side_a, out_side_b;
    logic       out_iphase, out_bstart, out_dvalid, out_tvalid, out_frame, out_sframe;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eqmux_top dut (.*);

    typedef struct packed {
        logic [7:0] i;
        logic [7:0] q;
        logic [3:0] conf;
        logic [7:0] h2;
        logic [1:0] kind;
        logic       first;
        logic [6:0] sym;
        logic [1:0] frm;
        logic       m8k;
        logic [4:0] exp_mk;   // bstart, dvalid, tvalid, frame, sframe
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'h11, 8'h91, 4'h1, 8'hA5, 2'd1, 1'b1, 7'd0, 2'd0, 1'b0, 5'b10000}, // Kmin on frame start
        '{8'h22, 8'h92, 4'h2, 8'h3C, 2'd1, 1'b0, 7'd0, 2'd0, 1'b0, 5'b01011}, // data, sym0 frm0 2K
        '{8'h33, 8'h93, 4'h3, 8'hF0, 2'd1, 1'b0, 7'd0, 2'd2, 1'b0, 5'b01010}, // 2K, frm 2
        '{8'h44, 8'h94, 4'h4, 8'h0F, 2'd1, 1'b0, 7'd0, 2'd2, 1'b1, 5'b01011}, // 8K, frm 2
        '{8'h55, 8'h95, 4'h5, 8'h5A, 2'd2, 1'b0, 7'd0, 2'd0, 1'b0, 5'b00100}, // TPS
        '{8'h66, 8'h96, 4'h6, 8'hC3, 2'd1, 1'b0, 7'd5, 2'd0, 1'b1, 5'b01000}, // data, sym5
        '{8'h77, 8'h97, 4'h7, 8'h81, 2'd0, 1'b0, 7'd0, 2'd0, 1'b0, 5'b00000}, // pilot
        '{8'h88, 8'h98, 4'h8, 8'h7E, 2'd3, 1'b0, 7'd0, 2'd0, 1'b1, 5'b00000}, // other
        '{8'h99, 8'h99, 4'h9, 8'h42, 2'd2, 1'b1, 7'd3, 2'd1, 1'b0, 5'b10000}  // Kmin tagged TPS
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] marks();
        return {out_bstart, out_dvalid, out_tvalid, out_frame, out_sframe};
    endfunction

    task automatic drive(input vec_t v);
        car_i = v.i; car_q = v.q; car_conf = v.conf; car_h2 = v.h2;
        car_kind = v.kind; car_first = v.first; sym_idx = v.sym;
        frm_idx = v.frm; mode_8k = v.m8k;
    endtask

    task automatic all_zero(input string req);
        chk({req, " data"}, 32'(out_data), 0);
        chk({req, " side"}, 32'({out_side_a, out_side_b}), 0);
        chk({req, " iph"}, 32'(out_iphase), 0);
        chk({req, " marks"}, 32'(marks()), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        all_zero("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, back to back: each offer lands in the previous Q cycle (R11)
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k]);
            car_vld = 1'b1;
            @(negedge clk);
            chk("R1/R11 I phase flag", 32'(out_iphase), 1);
            chk("R1 I data", 32'(out_data), 32'(VEC[k].i));
            chk("R3 conf on I", 32'(out_side_a), 32'(VEC[k].conf));
            chk("R4 low nibble I", 32'(out_side_b), 32'(VEC[k].h2[3:0]));
            chk("R5-R9 markers I", 32'(marks()), 32'(VEC[k].exp_mk));
            car_vld = 1'b0;
            @(negedge clk);
            chk("R1 Q phase flag", 32'(out_iphase), 0);
            chk("R1 Q data", 32'(out_data), 32'(VEC[k].q));
            chk("R3 h2 high on Q", 32'(out_side_a), 32'(VEC[k].h2[7:4]));
            chk("R4 low nibble Q", 32'(out_side_b), 32'(VEC[k].h2[3:0]));
            chk("R5-R9 markers Q", 32'(marks()), 32'(VEC[k].exp_mk));
        end
        @(negedge clk);
        all_zero("R10 idle after stream");

        // R2: offer during I phase is dropped
        drive(VEC[1]);
        car_vld = 1'b1;
        @(negedge clk);
        chk("R2 I of first", 32'(out_data), 32'h22);
        drive(VEC[4]);
        @(negedge clk);
        car_vld = 1'b0;
        chk("R2 Q keeps first", 32'(out_data), 32'h92);
        chk("R2 side_a keeps first", 32'(out_side_a), 32'h3);
        chk("R2 markers keep first", 32'(marks()), 32'b01011);
        @(negedge clk);
        all_zero("R2 dropped carrier absent");

        // R10: asynchronous reset in mid-carrier
        drive(VEC[0]);
        car_vld = 1'b1;
        @(negedge clk);
        car_vld = 1'b0;
        chk("R5 bstart before reset", 32'(out_bstart), 1);
        rst_n = 1'b0;
        #1;
        all_zero("R10 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        all_zero("R10 after release");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule